// File: doc/BRIEF.md
# Reorder Buffer with Tag Lookup

This block is a circular queue of result slots for an out-of-order core. The issue stage takes one slot for each instruction, in program order. The index of that slot becomes the instruction's rename tag. When a function unit finishes, it broadcasts the result on the common data bus. The broadcast carries the tag, a pair of data words, a pair of destination register numbers and a write enable for each. The slot named by the tag captures this payload and is marked complete. A double-precision result fits in one slot, using both halves of the pair.

Only the oldest slot may leave the queue. Once it is complete, it is shown on a retire port for exactly one cycle and freed at the following clock edge. This keeps termination in program order, even when younger instructions finish first. The retire port shows the tag as well, so the register file can drop a pending mark only when that mark still points at this tag.

A separate lookup port takes a tag and reports, in the same cycle, whether that slot holds a finished result that has not yet retired. If it does, the port also returns the slot's data. The issue logic uses this to pick up an operand straight from the buffer.

Top module: `rob_top`

## Requirements
- R1: During and after reset the buffer is empty: `alloc_ready_o` is 1, `alloc_tag_o` is 0, `ret_valid_o` is 0 and `lookup_hit_o` is 0 for every tag.
- R2: Each accepted allocation (`alloc_req_i` and `alloc_ready_o` high at a clock edge) receives the tag shown on `alloc_tag_o` before that edge. Successive tags count up by one and wrap from DEPTH-1 to 0.
- R3: After DEPTH allocations with no retirement, `alloc_ready_o` is 0. A request made while full is not accepted and leaves `alloc_tag_o` unchanged. Once a slot retires, allocation resumes with the next tag in sequence.
- R4: A bus cycle (`cdb_valid_i` high) whose tag names an allocated, not-yet-complete slot stores both data words, both destination numbers and both write enables in that slot, and marks it complete from the next cycle on.
- R5: A bus cycle whose tag names a slot that is not allocated has no effect: the lookup of that tag still misses, and the slot is not complete after it is later allocated.
- R6: Slots retire strictly in allocation order. `ret_valid_o` is 1 only while the oldest allocated slot is complete, and a complete younger slot waits behind an incomplete older one.
- R7: While `ret_valid_o` is 1, the retire port shows the oldest slot's tag, its data words, destination numbers and write enables. That slot is freed at the next edge, so each slot appears on the port in exactly one cycle.
- R8: `lookup_hit_o` is 1 exactly when the slot named by `lookup_tag_i` is allocated and complete. On a hit, `lookup_data0_o` and `lookup_data1_o` carry its data. The lookup misses again once the slot has retired.
- R9: At most one slot retires per cycle. A run of complete slots at the head retires in consecutive cycles, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 1 | Issue asks for a slot |
| alloc_ready_o | output | 1 | A slot is free |
| alloc_tag_o | output | $clog2(DEPTH) | Tag the next allocation receives |
| cdb_valid_i | input | 1 | Result broadcast valid |
| cdb_tag_i | input | $clog2(DEPTH) | Tag of the broadcast result |
| cdb_data0_i | input | DATA_W | Result word 0 |
| cdb_data1_i | input | DATA_W | Result word 1 |
| cdb_dst0_i | input | REG_W | Destination register 0 |
| cdb_dst1_i | input | REG_W | Destination register 1 |
| cdb_we0_i | input | 1 | Write enable for destination 0 |
| cdb_we1_i | input | 1 | Write enable for destination 1 |
| lookup_tag_i | input | $clog2(DEPTH) | Tag queried by issue |
| lookup_hit_o | output | 1 | Queried slot holds a finished result |
| lookup_data0_o | output | DATA_W | Word 0 of the queried slot |
| lookup_data1_o | output | DATA_W | Word 1 of the queried slot |
| ret_valid_o | output | 1 | Oldest slot retires this cycle |
| ret_tag_o | output | $clog2(DEPTH) | Tag of the oldest slot |
| ret_dst0_o | output | REG_W | Retiring destination 0 |
| ret_dst1_o | output | REG_W | Retiring destination 1 |
| ret_we0_o | output | 1 | Register write enable 0 |
| ret_we1_o | output | 1 | Register write enable 1 |
| ret_data0_o | output | DATA_W | Retiring word 0 |
| ret_data1_o | output | DATA_W | Retiring word 1 |

## Verification
Completion is driven in three orders, and each one tests something different:

- **Oldest first.** Each slot retires as soon as its result arrives.
- **Younger first, then the head.** Nothing may retire until the head completes. After that, the held-back results must leave in consecutive cycles.
- **Full buffer completed in reverse.** This run wraps the tags. It exercises the full stall and a refused request, then a drain of all DEPTH slots.

A broadcast to an unallocated tag is checked through the lookup port. This separates a design that guards on allocation from one that writes any slot the bus names. A scoreboard of allocation order catches any retirement that is out of order, repeated or premature.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int unsigned ROB_DEPTH_DEF  = 8;
  localparam int unsigned ROB_DATA_W_DEF = 32;
  localparam int unsigned ROB_REG_W_DEF  = 5;

  function automatic bit is_pow2(input int unsigned n);
    return (n != 0) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
  parameter int unsigned DEPTH = rob_pkg::ROB_DEPTH_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     adv_i,
  output logic [$clog2(DEPTH):0]   ptr_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam bit          POW2  = rob_pkg::is_pow2(DEPTH);

  // MSB is the wrap bit; low bits are the slot index
  generate
    if (POW2) begin : g_pow2
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    ptr_o <= '0;
        else if (adv_i) ptr_o <= ptr_o + 1'b1;
      end
    end else begin : g_mod
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ptr_o <= '0;
        else if (adv_i) begin
          if (ptr_o[IDX_W-1:0] == IDX_W'(DEPTH - 1)) ptr_o <= {~ptr_o[IDX_W], {IDX_W{1'b0}}};
          else                                       ptr_o <= ptr_o + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rob_store.sv
module rob_store #(
  parameter int unsigned DEPTH  = rob_pkg::ROB_DEPTH_DEF,
  parameter int unsigned DATA_W = rob_pkg::ROB_DATA_W_DEF,
  parameter int unsigned REG_W  = rob_pkg::ROB_REG_W_DEF
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_en_i,
  input  logic [$clog2(DEPTH)-1:0]   alloc_idx_i,
  input  logic                       cdb_valid_i,
  input  logic [$clog2(DEPTH)-1:0]   cdb_tag_i,
  input  logic [DATA_W-1:0]          cdb_data0_i,
  input  logic [DATA_W-1:0]          cdb_data1_i,
  input  logic [REG_W-1:0]           cdb_dst0_i,
  input  logic [REG_W-1:0]           cdb_dst1_i,
  input  logic                       cdb_we0_i,
  input  logic                       cdb_we1_i,
  input  logic                       ret_en_i,
  input  logic [$clog2(DEPTH)-1:0]   head_idx_i,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx_i,
  output logic                       head_done_o,
  output logic [DATA_W-1:0]          head_data0_o,
  output logic [DATA_W-1:0]          head_data1_o,
  output logic [REG_W-1:0]           head_dst0_o,
  output logic [REG_W-1:0]           head_dst1_o,
  output logic                       head_we0_o,
  output logic                       head_we1_o,
  output logic                       lkp_hit_o,
  output logic [DATA_W-1:0]          lkp_data0_o,
  output logic [DATA_W-1:0]          lkp_data1_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  busy_q, done_q, we0_q, we1_q;
  logic [DATA_W-1:0] d0_q   [DEPTH];
  logic [DATA_W-1:0] d1_q   [DEPTH];
  logic [REG_W-1:0]  dst0_q [DEPTH];
  logic [REG_W-1:0]  dst1_q [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic sel_alloc, sel_cdb, sel_ret;
      assign sel_alloc = alloc_en_i && (alloc_idx_i == IDX_W'(i));
      assign sel_ret   = ret_en_i && (head_idx_i == IDX_W'(i));
      // only an allocated, still pending slot accepts a broadcast
      assign sel_cdb   = cdb_valid_i && (cdb_tag_i == IDX_W'(i)) && busy_q[i] && !done_q[i];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          busy_q[i] <= 1'b0;
          done_q[i] <= 1'b0;
        end else begin
          if (sel_alloc)    busy_q[i] <= 1'b1;
          else if (sel_ret) busy_q[i] <= 1'b0;
          if (sel_alloc || sel_ret) done_q[i] <= 1'b0;
          else if (sel_cdb)         done_q[i] <= 1'b1;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          d0_q[i]   <= '0;
          d1_q[i]   <= '0;
          dst0_q[i] <= '0;
          dst1_q[i] <= '0;
          we0_q[i]  <= 1'b0;
          we1_q[i]  <= 1'b0;
        end else if (sel_cdb) begin
          d0_q[i]   <= cdb_data0_i;
          d1_q[i]   <= cdb_data1_i;
          dst0_q[i] <= cdb_dst0_i;
          dst1_q[i] <= cdb_dst1_i;
          we0_q[i]  <= cdb_we0_i;
          we1_q[i]  <= cdb_we1_i;
        end
      end

      assert_done_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_q[i] |-> busy_q[i]);
      assert_alloc_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_alloc |-> !busy_q[i]);
    end
  endgenerate

  assign head_done_o  = done_q[head_idx_i];
  assign head_data0_o = d0_q[head_idx_i];
  assign head_data1_o = d1_q[head_idx_i];
  assign head_dst0_o  = dst0_q[head_idx_i];
  assign head_dst1_o  = dst1_q[head_idx_i];
  assign head_we0_o   = we0_q[head_idx_i];
  assign head_we1_o   = we1_q[head_idx_i];

  assign lkp_hit_o   = done_q[rd_idx_i];
  assign lkp_data0_o = d0_q[rd_idx_i];
  assign lkp_data1_o = d1_q[rd_idx_i];

  assert_lookup_alloc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> busy_q[rd_idx_i]);
endmodule

// File: rtl/rob_top.sv
module rob_top #(
  parameter int unsigned DEPTH  = rob_pkg::ROB_DEPTH_DEF,
  parameter int unsigned DATA_W = rob_pkg::ROB_DATA_W_DEF,
  parameter int unsigned REG_W  = rob_pkg::ROB_REG_W_DEF
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_req_i,
  output logic                       alloc_ready_o,
  output logic [$clog2(DEPTH)-1:0]   alloc_tag_o,
  input  logic                       cdb_valid_i,
  input  logic [$clog2(DEPTH)-1:0]   cdb_tag_i,
  input  logic [DATA_W-1:0]          cdb_data0_i,
  input  logic [DATA_W-1:0]          cdb_data1_i,
  input  logic [REG_W-1:0]           cdb_dst0_i,
  input  logic [REG_W-1:0]           cdb_dst1_i,
  input  logic                       cdb_we0_i,
  input  logic                       cdb_we1_i,
  input  logic [$clog2(DEPTH)-1:0]   lookup_tag_i,
  output logic                       lookup_hit_o,
  output logic [DATA_W-1:0]          lookup_data0_o,
  output logic [DATA_W-1:0]          lookup_data1_o,
  output logic                       ret_valid_o,
  output logic [$clog2(DEPTH)-1:0]   ret_tag_o,
  output logic [REG_W-1:0]           ret_dst0_o,
  output logic [REG_W-1:0]           ret_dst1_o,
  output logic                       ret_we0_o,
  output logic                       ret_we1_o,
  output logic [DATA_W-1:0]          ret_data0_o,
  output logic [DATA_W-1:0]          ret_data1_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [IDX_W:0] head_q, tail_q;
  logic           full, empty, alloc_fire, ret_fire, head_done;

  assign empty      = (head_q == tail_q);
  assign full       = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) && (head_q[IDX_W] != tail_q[IDX_W]);
  assign alloc_fire = alloc_req_i && !full;
  assign ret_fire   = head_done && !empty;

  rob_ptr #(.DEPTH(DEPTH)) u_tail (
    .clk_i (clk_i), .rst_ni(rst_ni), .adv_i(alloc_fire), .ptr_o(tail_q));

  rob_ptr #(.DEPTH(DEPTH)) u_head (
    .clk_i (clk_i), .rst_ni(rst_ni), .adv_i(ret_fire), .ptr_o(head_q));

  rob_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_en_i  (alloc_fire),
    .alloc_idx_i (tail_q[IDX_W-1:0]),
    .cdb_valid_i (cdb_valid_i),
    .cdb_tag_i   (cdb_tag_i),
    .cdb_data0_i (cdb_data0_i),
    .cdb_data1_i (cdb_data1_i),
    .cdb_dst0_i  (cdb_dst0_i),
    .cdb_dst1_i  (cdb_dst1_i),
    .cdb_we0_i   (cdb_we0_i),
    .cdb_we1_i   (cdb_we1_i),
    .ret_en_i    (ret_fire),
    .head_idx_i  (head_q[IDX_W-1:0]),
    .rd_idx_i    (lookup_tag_i),
    .head_done_o (head_done),
    .head_data0_o(ret_data0_o),
    .head_data1_o(ret_data1_o),
    .head_dst0_o (ret_dst0_o),
    .head_dst1_o (ret_dst1_o),
    .head_we0_o  (ret_we0_o),
    .head_we1_o  (ret_we1_o),
    .lkp_hit_o   (lookup_hit_o),
    .lkp_data0_o (lookup_data0_o),
    .lkp_data1_o (lookup_data1_o)
  );

  assign alloc_ready_o = !full;
  assign alloc_tag_o   = tail_q[IDX_W-1:0];
  assign ret_valid_o   = ret_fire;
  assign ret_tag_o     = head_q[IDX_W-1:0];

  assert_full_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_req_i && !alloc_ready_o) |=> $stable(alloc_tag_o));
  assert_head_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_valid_o |=> $stable(ret_tag_o));
  assert_head_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |=> (int'(ret_tag_o) == ((int'($past(ret_tag_o)) + 1) % int'(DEPTH))));
  assert_retire_nonempty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |-> !alloc_ready_o || (alloc_tag_o != ret_tag_o));
endmodule

// File: tb/rob_top_tb.sv
module rob_top_tb;
  localparam int DEPTH = 8;
  localparam int DW    = 32;
  localparam int RW    = 5;
  localparam int TW    = 3;

  logic clk = 1'b0;
  logic rst_ni;
  logic alloc_req_i, alloc_ready_o;
  logic [TW-1:0] alloc_tag_o;
  logic cdb_valid_i, cdb_we0_i, cdb_we1_i;
  logic [TW-1:0] cdb_tag_i, lookup_tag_i, ret_tag_o;
  logic [DW-1:0] cdb_data0_i, cdb_data1_i, lookup_data0_o, lookup_data1_o, ret_data0_o, ret_data1_o;
  logic [RW-1:0] cdb_dst0_i, cdb_dst1_i, ret_dst0_o, ret_dst1_o;
  logic lookup_hit_o, ret_valid_o, ret_we0_o, ret_we1_o;

  always #10 clk = ~clk;

  rob_top #(.DEPTH(DEPTH), .DATA_W(DW), .REG_W(RW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_req_i(alloc_req_i), .alloc_ready_o(alloc_ready_o), .alloc_tag_o(alloc_tag_o),
    .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i),
    .cdb_data0_i(cdb_data0_i), .cdb_data1_i(cdb_data1_i),
    .cdb_dst0_i(cdb_dst0_i), .cdb_dst1_i(cdb_dst1_i),
    .cdb_we0_i(cdb_we0_i), .cdb_we1_i(cdb_we1_i),
    .lookup_tag_i(lookup_tag_i), .lookup_hit_o(lookup_hit_o),
    .lookup_data0_o(lookup_data0_o), .lookup_data1_o(lookup_data1_o),
    .ret_valid_o(ret_valid_o), .ret_tag_o(ret_tag_o),
    .ret_dst0_o(ret_dst0_o), .ret_dst1_o(ret_dst1_o),
    .ret_we0_o(ret_we0_o), .ret_we1_o(ret_we1_o),
    .ret_data0_o(ret_data0_o), .ret_data1_o(ret_data1_o)
  );

  int checks = 0;
  int errors = 0;
  int retired = 0;
  int q_tags[$];
  logic [DW-1:0] exp_d0 [DEPTH];
  logic [DW-1:0] exp_d1 [DEPTH];
  logic [RW-1:0] exp_r0 [DEPTH];
  logic [RW-1:0] exp_r1 [DEPTH];
  logic          exp_w0 [DEPTH];
  logic          exp_w1 [DEPTH];
  logic          exp_done [DEPTH];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic alloc_one(input int tag);
    alloc_req_i = 1'b1;
    #2;
    chk("R2", "alloc_ready", alloc_ready_o, 1);
    chk("R2", "alloc_tag", alloc_tag_o, tag);
    tick();
    alloc_req_i = 1'b0;
    q_tags.push_back(tag);
  endtask

  task automatic cdb_send(input int tag, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                          input logic [RW-1:0] r0, input logic [RW-1:0] r1,
                          input logic w0, input logic w1, input bit live);
    cdb_valid_i = 1'b1; cdb_tag_i = TW'(tag);
    cdb_data0_i = d0; cdb_data1_i = d1; cdb_dst0_i = r0; cdb_dst1_i = r1;
    cdb_we0_i = w0; cdb_we1_i = w1;
    if (live) begin
      exp_d0[tag] = d0; exp_d1[tag] = d1; exp_r0[tag] = r0; exp_r1[tag] = r1;
      exp_w0[tag] = w0; exp_w1[tag] = w1; exp_done[tag] = 1'b1;
    end
    tick();
    cdb_valid_i = 1'b0;
  endtask

  task automatic look(input string req, input int tag, input logic hit);
    lookup_tag_i = TW'(tag);
    #1;
    chk(req, "lookup_hit", lookup_hit_o, hit);
    if (hit) begin
      chk(req, "lookup_data0", lookup_data0_o, exp_d0[tag]);
      chk(req, "lookup_data1", lookup_data1_o, exp_d1[tag]);
    end
  endtask

  // monitor: scoreboard of allocation order against the retire port
  always @(negedge clk) begin : mon
    int t;
    if (rst_ni === 1'b1 && ret_valid_o === 1'b1) begin
      if (q_tags.size() == 0) begin
        chk("R6", "retire with nothing allocated", 1, 0);
      end else begin
        t = q_tags.pop_front();
        chk("R6", "retire order tag", ret_tag_o, t);
        chk("R6", "retired slot completed", exp_done[t], 1);
        chk("R7", "ret_data0", ret_data0_o, exp_d0[t]);
        chk("R7", "ret_data1", ret_data1_o, exp_d1[t]);
        chk("R7", "ret_dst0", ret_dst0_o, exp_r0[t]);
        chk("R7", "ret_dst1", ret_dst1_o, exp_r1[t]);
        chk("R7", "ret_we0", ret_we0_o, exp_w0[t]);
        chk("R7", "ret_we1", ret_we1_o, exp_w1[t]);
        exp_done[t] = 1'b0;
        retired++;
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < DEPTH; i++) exp_done[i] = 1'b0;
    rst_ni = 1'b0; alloc_req_i = 1'b0; cdb_valid_i = 1'b0; cdb_tag_i = '0;
    cdb_data0_i = '0; cdb_data1_i = '0; cdb_dst0_i = '0; cdb_dst1_i = '0;
    cdb_we0_i = 1'b0; cdb_we1_i = 1'b0; lookup_tag_i = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_ni = 1'b1;
    #1;
    // R1
    chk("R1", "alloc_ready after reset", alloc_ready_o, 1);
    chk("R1", "alloc_tag after reset", alloc_tag_o, 0);
    chk("R1", "ret_valid after reset", ret_valid_o, 0);
    look("R1", 0, 1'b0);
    tick();

    // younger finishes first, head later
    alloc_one(0); alloc_one(1); alloc_one(2);
    look("R8", 0, 1'b0);
    cdb_send(2, 32'hA2A2_0002, 32'hB2B2_0002, 5'd3, 5'd4, 1'b1, 1'b0, 1'b1);
    look("R4", 2, 1'b1);
    chk("R6", "younger done, head pending", ret_valid_o, 0);
    cdb_send(0, 32'hA0A0_0000, 32'hB0B0_0000, 5'd10, 5'd11, 1'b1, 1'b1, 1'b1);
    tick();
    chk("R6", "head 1 pending blocks tag 2", ret_valid_o, 0);
    look("R8", 0, 1'b0);
    chk("R6", "retired count", retired, 1);
    cdb_send(1, 32'hA1A1_0001, 32'hB1B1_0001, 5'd20, 5'd0, 1'b0, 1'b0, 1'b1);
    tick();
    chk("R9", "one retirement per cycle", retired, 2);
    tick();
    chk("R9", "back-to-back retirement", retired, 3);
    chk("R9", "queue idle", ret_valid_o, 0);

    // stray broadcast to unallocated slot 5
    cdb_send(5, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd7, 5'd7, 1'b1, 1'b1, 1'b0);
    look("R5", 5, 1'b0);

    // fill with wrap: tags 3..7,0,1,2
    for (int k = 0; k < DEPTH; k++) alloc_one((3 + k) % DEPTH);
    look("R5", 5, 1'b0);
    chk("R3", "alloc_ready when full", alloc_ready_o, 0);
    alloc_req_i = 1'b1;
    tick(); tick();
    #1;
    chk("R3", "alloc_tag held while full", alloc_tag_o, 3);
    chk("R3", "still full", alloc_ready_o, 0);
    alloc_req_i = 1'b0;

    // complete in reverse, head last
    for (int k = DEPTH - 1; k >= 1; k--) begin
      int t;
      t = (3 + k) % DEPTH;
      cdb_send(t, 32'h1000_0000 + t, 32'h2000_0000 + t, RW'(t), RW'(t + 8), 1'b1, t[0], 1'b1);
    end
    chk("R6", "no retire while head pending", retired, 3);
    look("R8", 6, 1'b1);
    cdb_send(3, 32'h1000_0003, 32'h2000_0003, 5'd3, 5'd11, 1'b1, 1'b1, 1'b1);
    tick();
    chk("R3", "ready after first retire", alloc_ready_o, 1);
    chk("R3", "next tag after full", alloc_tag_o, 3);
    for (int k = 0; k < DEPTH - 1; k++) tick();
    chk("R9", "full drain retirements", retired, 11);
    chk("R6", "drained", ret_valid_o, 0);
    look("R8", 6, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule